// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block takes the raw D+ and D- levels of a low-speed USB link, sampled by a system clock that runs at eight times the bit rate, and recovers the bytes of each packet. Both line inputs first pass through a two-stage synchronizer. The block then waits for the first J-to-K transition and checks the sync field. Sampling is aligned to the last J-to-K edge of the sync field, and lock is declared only when two K bits arrive back to back. After lock it samples every bit near its centre, undoes the NRZI coding, drops stuffed bits and shifts the bits into bytes least significant bit first.

Each finished byte appears on a one-cycle strobe. A single-ended zero ends the packet and produces a one-cycle end pulse with the count of whole bytes. The byte store has a fixed capacity, and a packet that needs more room is aborted with an overflow pulse. If the sync search stalls, a sync-error pulse is raised. PID decoding, CRC and the layers above them are left to the logic downstream.

Top module: `usbLsRx`

## Requirements
- R1: After reset `byteValid`, `pktEnd`, `errOverflow` and `errSync` are low, and the line reads as idle J (D+ low, D- high).
- R2: A J-to-K edge starts a check one and a half bit times later. A K there (D+ high, D- low) locks the receiver. A J there returns it to the search, where a later J-to-K edge can still lock it.
- R3: After lock, a data bit decodes as 1 when the D- level equals the previous bit's level and as 0 when it differs. The final K of the sync field is the reference for the first data bit.
- R4: The run of decoded ones starts at zero at lock and carries across byte boundaries. The line bit after six ones is discarded, and its level becomes the new reference.
- R5: Every eighth decoded bit completes a byte. The first decoded bit is bit 0 of `byteData`. The byte is shown for exactly one cycle with `byteValid`.
- R6: A single-ended zero (both lines low) sampled at bit position 1 to 7 of a byte ends the packet. `pktEnd` pulses with `pktLen` equal to the number of whole bytes, and the partial byte produces no strobe.
- R7: A single-ended zero sampled at bit position 0 of a byte does not end the packet. It decodes as a K level, so data that carries K there comes out unchanged.
- R8: With capacity `BUF_BYTES`, a packet of up to `BUF_BYTES` bytes is delivered whole. Byte number `BUF_BYTES`+1 produces no strobe but a one-cycle `errOverflow`. That packet then gives no `pktEnd`, and the block returns to idle.
- R9: If `SYNC_TIMEOUT` clocks pass in the search without a J-to-K edge, `errSync` pulses once. No byte or end pulse follows, and the block returns to idle.
- R10: A packet with no data bytes, whose sync field is followed directly by the end of packet, gives `pktEnd` with `pktLen` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `OVERSAMPLE` times the bit rate |
| rstN | input | 1 | Active-low synchronous reset |
| dPlusIn | input | 1 | Raw D+ line level |
| dMinusIn | input | 1 | Raw D- line level |
| byteValid | output | 1 | One-cycle strobe for a received byte |
| byteData | output | 8 | Received byte, valid with `byteValid` |
| pktEnd | output | 1 | One-cycle end-of-packet pulse |
| pktLen | output | $clog2(BUF_BYTES+1) | Whole bytes in the packet, valid with `pktEnd` |
| errOverflow | output | 1 | One-cycle pulse when a packet exceeds the capacity |
| errSync | output | 1 | One-cycle pulse when the sync search times out |

## Verification
The removal of a stuffed bit and the completion of a byte can fall on the same run of samples. A byte of all ones ends with ones still counted, so the stuffed bit can land on the slot where the next byte's bit 0 is expected. The bench provokes this with directed bursts of 0xFF and with random packets that are heavy in 0xFF. It judges the result by comparing every strobed byte, the byte count and the end pulse against a bench encoder that inserts stuffing on its own. A second overlap occurs at a byte's bit 0, where a single-ended zero must be decoded as data and not end the packet. The bench overwrites K-level bit-0 symbols with single-ended zeros and expects the same bytes back.

// File: rtl/usbLsRxPkg.sv
package usbLsRxPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_HUNT  = 2'd2,
    ST_RECV  = 2'd3
  } rxState_t;

  typedef struct packed {
    logic lock;
    logic sample;
  } rxStrobe_t;
endpackage

// File: rtl/usbLsRxCtrl.sv
module usbLsRxCtrl
  import usbLsRxPkg::*;
#(
  parameter int OVERSAMPLE   = 8,
  parameter int SYNC_TIMEOUT = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineJtoK,
  input  logic      lineK,
  input  logic      stopNow,
  output rxStrobe_t strobe,
  output logic      errSync
);
  localparam int CHECK_AT = OVERSAMPLE + OVERSAMPLE / 2;
  localparam int MAX_T    = (CHECK_AT > SYNC_TIMEOUT) ? CHECK_AT : SYNC_TIMEOUT;
  localparam int TMR_W    = $clog2(MAX_T + 1);

  rxState_t state;
  logic [TMR_W-1:0] tmr;

  always_comb begin
    strobe.lock   = (state == ST_ALIGN) && (tmr == TMR_W'(CHECK_AT)) && lineK;
    strobe.sample = (state == ST_RECV) && (tmr == TMR_W'(OVERSAMPLE - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      errSync <= 1'b0;
    end else begin
      errSync <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (lineJtoK) begin
            state <= ST_ALIGN;
            tmr   <= TMR_W'(1);
          end
        end
        ST_ALIGN: begin
          if (tmr == TMR_W'(CHECK_AT)) begin
            state <= lineK ? ST_RECV : ST_HUNT;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_HUNT: begin
          if (lineJtoK) begin
            state <= ST_ALIGN;
            tmr   <= TMR_W'(1);
          end else if (tmr == TMR_W'(SYNC_TIMEOUT - 1)) begin
            state   <= ST_IDLE;
            tmr     <= '0;
            errSync <= 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_RECV: begin
          if (stopNow) begin
            state <= ST_IDLE;
            tmr   <= '0;
          end else if (tmr == TMR_W'(OVERSAMPLE - 1)) begin
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the receive state is entered only after a K seen at the check point
  assert_lock_on_k_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_RECV) |-> $past(lineK));

  // R9: a sync error comes only out of the search state
  assert_sync_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    errSync |-> ($past(state) == ST_HUNT));

  // R9: after a sync error the block sits idle
  assert_sync_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    errSync |-> (state == ST_IDLE));
endmodule

// File: rtl/usbLsRxDatapath.sv
module usbLsRxDatapath
  import usbLsRxPkg::*;
#(
  parameter int BUF_BYTES   = 11,
  parameter int SYNC_STAGES = 2,
  parameter int STUFF_RUN   = 6,
  localparam int CNT_W      = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dPlusIn,
  input  logic             dMinusIn,
  input  rxStrobe_t        strobe,
  output logic             lineJtoK,
  output logic             lineK,
  output logic             stopNow,
  output logic             byteValid,
  output logic [7:0]       byteData,
  output logic             pktEnd,
  output logic [CNT_W-1:0] pktLen,
  output logic             errOverflow
);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam logic [2:0] LAST_BIT = 3'd7;

  logic [SYNC_STAGES-1:0] dpPipe, dmPipe;
  logic dpS, dmS, dmPrev;
  logic se0, endHit, stuffSlot, newBit, byteDone, ovfHit;
  logic lastLevel;
  logic [2:0] bitPos;
  logic [RUN_W-1:0] onesRun;
  logic [6:0] shiftReg;
  logic [7:0] assembled;
  logic [CNT_W-1:0] byteCount;

  // two-stage synchronizer, idle J at reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dpPipe <= '0;
      dmPipe <= '1;
      dmPrev <= 1'b1;
    end else begin
      dpPipe <= {dpPipe[SYNC_STAGES-2:0], dPlusIn};
      dmPipe <= {dmPipe[SYNC_STAGES-2:0], dMinusIn};
      dmPrev <= dmS;
    end
  end

  always_comb begin
    dpS       = dpPipe[SYNC_STAGES-1];
    dmS       = dmPipe[SYNC_STAGES-1];
    lineK     = dpS && !dmS;
    lineJtoK  = dmPrev && lineK;
    se0       = !dpS && !dmS;
    endHit    = strobe.sample && se0 && (bitPos != 3'd0);
    stuffSlot = (onesRun == RUN_W'(STUFF_RUN));
    newBit    = (dmS == lastLevel);
    assembled = {newBit, shiftReg};
    byteDone  = strobe.sample && !endHit && !stuffSlot && (bitPos == LAST_BIT);
    ovfHit    = byteDone && (byteCount == CNT_W'(BUF_BYTES));
    stopNow   = endHit || ovfHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastLevel   <= 1'b1;
      bitPos      <= '0;
      onesRun     <= '0;
      shiftReg    <= '0;
      byteCount   <= '0;
      byteValid   <= 1'b0;
      byteData    <= '0;
      pktEnd      <= 1'b0;
      pktLen      <= '0;
      errOverflow <= 1'b0;
    end else begin
      byteValid   <= 1'b0;
      pktEnd      <= 1'b0;
      errOverflow <= 1'b0;
      if (strobe.lock) begin
        lastLevel <= 1'b0;
        bitPos    <= '0;
        onesRun   <= '0;
        byteCount <= '0;
      end else if (strobe.sample) begin
        if (endHit) begin
          pktEnd <= 1'b1;
          pktLen <= byteCount;
        end else if (stuffSlot) begin
          onesRun   <= '0;
          lastLevel <= dmS;
        end else begin
          lastLevel <= dmS;
          onesRun   <= newBit ? onesRun + 1'b1 : '0;
          shiftReg  <= assembled[7:1];
          bitPos    <= bitPos + 1'b1;
          if (byteDone) begin
            if (ovfHit) begin
              errOverflow <= 1'b1;
            end else begin
              byteValid <= 1'b1;
              byteData  <= assembled;
              byteCount <= byteCount + 1'b1;
            end
          end
        end
      end
    end
  end

  // R4: the ones run never passes the stuffing limit
  always @(posedge clk) begin
    if (rstN) begin
      assert_ones_cap_R4: assert (onesRun <= RUN_W'(STUFF_RUN));
    end
  end

  // R5: bytes are at least a bit time apart, so a strobe lasts one cycle
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R8: a strobed byte never lies beyond the capacity
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> (byteCount <= CNT_W'(BUF_BYTES)));

  // R6: the reported length stays within the capacity
  assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    pktEnd |-> (pktLen <= CNT_W'(BUF_BYTES)));

  // R8: an aborted packet never ends normally in the same cycle
  assert_abort_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    errOverflow |-> !pktEnd && !byteValid);
endmodule

// File: rtl/usbLsRx.sv
module usbLsRx
  import usbLsRxPkg::*;
#(
  parameter int OVERSAMPLE   = 8,
  parameter int BUF_BYTES    = 11,
  parameter int SYNC_TIMEOUT = 24,
  localparam int CNT_W       = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dPlusIn,
  input  logic             dMinusIn,
  output logic             byteValid,
  output logic [7:0]       byteData,
  output logic             pktEnd,
  output logic [CNT_W-1:0] pktLen,
  output logic             errOverflow,
  output logic             errSync
);
  rxStrobe_t strobe;
  logic lineJtoK, lineK, stopNow;

  usbLsRxCtrl #(
    .OVERSAMPLE  (OVERSAMPLE),
    .SYNC_TIMEOUT(SYNC_TIMEOUT)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .lineJtoK(lineJtoK),
    .lineK   (lineK),
    .stopNow (stopNow),
    .strobe  (strobe),
    .errSync (errSync)
  );

  usbLsRxDatapath #(
    .BUF_BYTES  (BUF_BYTES),
    .SYNC_STAGES(2),
    .STUFF_RUN  (6)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .dPlusIn    (dPlusIn),
    .dMinusIn   (dMinusIn),
    .strobe     (strobe),
    .lineJtoK   (lineJtoK),
    .lineK      (lineK),
    .stopNow    (stopNow),
    .byteValid  (byteValid),
    .byteData   (byteData),
    .pktEnd     (pktEnd),
    .pktLen     (pktLen),
    .errOverflow(errOverflow)
  );
endmodule

// File: tb/test_usbLsRx.sv
module test_usbLsRx;
  localparam int BUF   = 11;
  localparam int CW    = $clog2(BUF + 1);
  localparam int OS    = 8;
  localparam logic [1:0] SYM_J = 2'b01;  // {dp,dm}
  localparam logic [1:0] SYM_K = 2'b10;
  localparam logic [1:0] SYM_Z = 2'b00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dp = 1'b0, dm = 1'b1;
  logic byteValid, pktEnd, errOverflow, errSync;
  logic [7:0] byteData;
  logic [CW-1:0] pktLen;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  int byteTotal = 0, endTotal = 0, ovfTotal = 0, syncTotal = 0;
  int lastLen = 0;
  logic [7:0] gotBytes [0:63];

  logic [1:0] symBuf [0:1023];
  int symLen;
  logic curLevel;
  int ones;
  logic [7:0] txBytes [0:15];

  always #5 clk = ~clk;

  usbLsRx #(.OVERSAMPLE(OS), .BUF_BYTES(BUF), .SYNC_TIMEOUT(24)) i_usbLsRx (
    .clk(clk), .rstN(rstN), .dPlusIn(dp), .dMinusIn(dm),
    .byteValid(byteValid), .byteData(byteData), .pktEnd(pktEnd),
    .pktLen(pktLen), .errOverflow(errOverflow), .errSync(errSync));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (byteValid) begin gotBytes[byteTotal % 64] <= byteData; byteTotal <= byteTotal + 1; end
      if (pktEnd) begin endTotal <= endTotal + 1; lastLen <= int'(pktLen); end
      if (errOverflow) ovfTotal <= ovfTotal + 1;
      if (errSync) syncTotal <= syncTotal + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic putSym(input logic [1:0] s);
    symBuf[symLen] = s;
    symLen++;
  endtask

  task automatic putLevel(input logic lvl);
    putSym(lvl ? SYM_J : SYM_K);
  endtask

  // NRZI with stuffing emitted right after the sixth one
  task automatic putBit(input logic b);
    if (!b) curLevel = ~curLevel;
    putLevel(curLevel);
    ones = b ? ones + 1 : 0;
    if (ones == 6) begin
      curLevel = ~curLevel;
      putLevel(curLevel);
      ones = 0;
    end
  endtask

  task automatic build(input int n, input int tail, input bit glitch);
    logic [7:0] tb;
    symLen = 0;
    for (int i = 0; i < 4; i++) putSym(SYM_J);
    putSym(SYM_K); putSym(SYM_J); putSym(SYM_K); putSym(SYM_J);
    putSym(SYM_K); putSym(SYM_J); putSym(SYM_K); putSym(SYM_K);
    curLevel = 1'b0;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        int idx;
        idx = symLen;
        putBit(txBytes[i][b]);
        // R7: a K-level bit 0 replaced by a single-ended zero
        if (glitch && b == 0 && symBuf[idx] == SYM_K) symBuf[idx] = SYM_Z;
      end
    end
    tb = 8'($urandom);
    for (int b = 0; b < tail; b++) putBit(tb[b]);
    putSym(SYM_Z); putSym(SYM_Z);
    for (int i = 0; i < 6; i++) putSym(SYM_J);
  endtask

  task automatic play();
    for (int i = 0; i < symLen; i++) begin
      @(negedge clk);
      {dp, dm} = symBuf[i];
      repeat (OS - 1) @(negedge clk);
    end
    repeat (4 * OS) @(negedge clk);
  endtask

  task automatic runPacket(input int n, input int tail, input bit glitch, input string req);
    int b0, e0, o0, s0, expN, bad, firstAct, firstExp;
    b0 = byteTotal; e0 = endTotal; o0 = ovfTotal; s0 = syncTotal;
    build(n, tail, glitch);
    play();
    expN = (n > BUF) ? BUF : n;
    chk(req, "byte count", byteTotal - b0, expN);
    bad = 0; firstAct = 0; firstExp = 0;
    for (int i = 0; i < expN && i < byteTotal - b0; i++) begin
      if (gotBytes[(b0 + i) % 64] !== txBytes[i]) begin
        if (bad == 0) begin firstAct = int'(gotBytes[(b0 + i) % 64]); firstExp = int'(txBytes[i]); end
        bad++;
      end
    end
    chk(req, "byte value (R3/R5)", firstAct, firstExp);
    if (n > BUF) begin
      chk("R8", "overflow pulses", ovfTotal - o0, 1);
      chk("R8", "end pulses after abort", endTotal - e0, 0);
    end else begin
      chk("R6", "end pulses", endTotal - e0, 1);
      chk("R6", "packet length", lastLen, n);
      chk("R8", "overflow pulses", ovfTotal - o0, 0);
    end
    chk("R9", "no sync error", syncTotal - s0, 0);
  endtask

  initial begin
    repeat (200000 - 50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all requirements: actual %0d cycles expected fewer", cyc);
    summary();
  end

  initial begin
    int b0, e0, s0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "byteValid at reset", int'(byteValid), 0);
    chk("R1", "pktEnd at reset", int'(pktEnd), 0);
    chk("R1", "errors at reset", int'(errOverflow | errSync), 0);
    repeat (40) @(negedge clk);
    chk("R1", "idle line gives no event", byteTotal + endTotal + ovfTotal + syncTotal, 0);

    // R10: empty packet
    runPacket(0, 0, 0, "R10");

    // R3/R5: single byte patterns
    txBytes[0] = 8'h00; runPacket(1, 0, 0, "R3");
    txBytes[0] = 8'hA5; txBytes[1] = 8'h3C; runPacket(2, 0, 0, "R5");

    // R4: stuffed bits across byte boundaries
    for (int i = 0; i < 4; i++) txBytes[i] = 8'hFF;
    runPacket(4, 0, 0, "R4");
    txBytes[0] = 8'hFC; txBytes[1] = 8'h3F; txBytes[2] = 8'hFF; txBytes[3] = 8'h7E;
    runPacket(4, 0, 0, "R4");

    // R8: exactly full, then one too many
    for (int i = 0; i < 12; i++) txBytes[i] = 8'(i * 37 + 5);
    runPacket(BUF, 0, 0, "R8");
    runPacket(BUF + 1, 0, 0, "R8");

    // R6: partial byte discarded
    txBytes[0] = 8'h12; txBytes[1] = 8'h34; runPacket(2, 3, 0, "R6");
    runPacket(2, 7, 0, "R6");

    // R7: single-ended zero at bit 0 ignored
    for (int i = 0; i < 6; i++) txBytes[i] = 8'hAA ^ 8'(i);
    runPacket(6, 0, 1, "R7");

    // R9: lone K pulse times out
    b0 = byteTotal; e0 = endTotal; s0 = syncTotal;
    symLen = 0;
    putSym(SYM_J); putSym(SYM_K);
    for (int i = 0; i < 8; i++) putSym(SYM_J);
    play();
    chk("R9", "sync error pulses", syncTotal - s0, 1);
    chk("R9", "no bytes after sync error", byteTotal - b0, 0);
    chk("R9", "no end after sync error", endTotal - e0, 0);

    // R2: failed double-K check, then real packet within the search window
    b0 = byteTotal; e0 = endTotal; s0 = syncTotal;
    txBytes[0] = 8'h5A; txBytes[1] = 8'hC3;
    build(2, 0, 0);
    for (int i = 0; i < 4; i++) symBuf[i] = (i == 1) ? SYM_K : SYM_J;
    play();
    chk("R2", "bytes after false start", byteTotal - b0, 2);
    chk("R2", "byte 0 after false start", int'(gotBytes[b0 % 64]), 8'h5A);
    chk("R2", "end after false start", endTotal - e0, 1);
    chk("R2", "no sync error on retry", syncTotal - s0, 0);

    // random packets, heavy in 0xFF
    for (int p = 0; p < 40; p++) begin
      int n;
      n = int'($urandom_range(0, BUF + 1));
      for (int i = 0; i < n; i++)
        txBytes[i] = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom);
      runPacket(n, (n > BUF) ? 0 : int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                (n > BUF) ? "R8" : "R4");
    end

    summary();
  end
endmodule